// File: doc/BRIEF.md
# PHY Management Register Emulator

This block stands in for the management side of a gigabit Ethernet PHY. A host works it through a single 32-bit command register. One command word carries a PHY register number, a 16-bit data field, an opcode, and a completion-interrupt enable. The block runs the access one cycle after the word is written. It then returns the result in the same register, with a ready flag and, where the access was not allowed, an error flag.

A write to the PHY control register can also start auto-negotiation. The link is then reported down for a fixed number of clock cycles and afterwards comes back up with negotiation marked complete. The block exports the link-up state, the loopback selection from the control register, and one interrupt request. That request is built from a two-bit cause register and a two-bit mask register.

Top module: `phy_mgmt_emu`

## Requirements
- R1: A write on `cmd_wr` stores the command word with ready (bit 28) and error (bit 30) cleared. The cycle after that, the command completes: ready reads 1 and the other fields keep their values, except as R2 and R3 state.
- R2: The command word holds data in bits 15:0, the register number in bits 20:16 and the opcode in bits 27:26 (01 write, 10 read). A read of a readable register places its value in bits 15:0. Readable registers are 0, 1, 2, 3, 4, 5, 9, 10, 16, 17 and 20. After reset, register 0 reads 0x1140, register 1 reads 0x794D and register 2 reads 0x0141.
- R3: A write to a register that is not writable (writable are 0, 4, 9, 16, 20) leaves it unchanged and sets error bit 30. A read of a register that is not readable also sets bit 30 and leaves bits 15:0 as written.
- R4: A write to a writable register stores the data, and a later read returns it.
- R5: Cause bit 0 (command done) is set on completion only when bit 29 of the command word is 1.
- R6: `irq` is high exactly when mask AND cause is nonzero. A pulse on `cause_ack_wr` clears the cause bits that are set in `cause_ack_bits`.
- R7: A write to register 0 with bit 12 and bit 9 both 1 drops `link_up`. It also clears status bit 2 (link) and status bit 5 (negotiation complete), so status reads 0x7949.
- R8: Exactly `DELAY_CYC` cycles after the starting write completes, `link_up` returns to 1, status bit 5 becomes 1 (status reads 0x796D) and cause bit 1 is set.
- R9: A new start while a delay is pending reloads the full delay.
- R10: `loopback` follows register 0 bit 14. A control write that lacks bit 12 or bit 9 does not disturb the link.
- R11: Reset cancels a pending delay and reloads all reset values. During reset, `link_up` (and status bit 2) is taken from `wire_link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wire_link_ok | input | 1 | External link state, sampled during reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Command register contents |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 2 | New interrupt mask |
| cause_ack_wr | input | 1 | Clear strobe for the cause register |
| cause_ack_bits | input | 2 | Cause bits to clear |
| cause | output | 2 | Cause register (bit 0 command done, bit 1 negotiation done) |
| irq | output | 1 | Interrupt request |
| link_up | output | 1 | Link-up status |
| loopback | output | 1 | Loopback selected in the control register |

## Verification
A table of command words covers the register file. It mixes reads of registers with reset values, a write and read-back of a writable register, a write to a read-only register, and a read of an absent register. Together these separate the readable, writable and absent capabilities and show that a refused write leaves the stored value intact. Control-register writes are tried in three forms: enable plus restart, restart without enable, and the loopback bit alone. These show which bit combination starts negotiation. The delay is probed on the last cycle of link-down and the first cycle of link-up, and a restart during the wait proves the reload. A reset in mid-delay and a reset with the external link down cover the cancel path and the sampled link.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int NREG    = 1 << ADDR_W;
  localparam int CMD_W   = 32;
  localparam int CAUSE_W = 2;

  // command word fields
  localparam int F_REG_LSB = 16;
  localparam int F_OP_LSB  = 26;
  localparam int B_READY   = 28;
  localparam int B_IE      = 29;
  localparam int B_ERR     = 30;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSV  = 2'b11
  } mdi_op_e;

  // cause bits
  localparam int CS_MDI = 0;
  localparam int CS_AN  = 1;

  // register numbers and bit positions used by the logic
  localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
  localparam int CTRL_AN_RST  = 9;
  localparam int CTRL_AN_EN   = 12;
  localparam int CTRL_LOOP    = 14;
  localparam int STAT_LINK    = 2;
  localparam int STAT_AN_DONE = 5;

  function automatic logic reg_can_rd(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd9, 5'd10,
      5'd16, 5'd17, 5'd20: reg_can_rd = 1'b1;
      default:             reg_can_rd = 1'b0;
    endcase
  endfunction

  function automatic logic reg_can_wr(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0, 5'd4, 5'd9, 5'd16, 5'd20: reg_can_wr = 1'b1;
      default:                        reg_can_wr = 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_reset(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0:    reg_reset = 16'h1140;
      5'd1:    reg_reset = 16'h794D;
      5'd2:    reg_reset = 16'h0141;
      5'd3:    reg_reset = 16'h0C20;
      5'd4:    reg_reset = 16'h0DE1;
      5'd5:    reg_reset = 16'h01E0;
      5'd9:    reg_reset = 16'h0E00;
      5'd10:   reg_reset = 16'h3C00;
      5'd16:   reg_reset = 16'h0360;
      5'd17:   reg_reset = 16'hAC00;
      5'd20:   reg_reset = 16'h0D60;
      default: reg_reset = '0;
    endcase
  endfunction

endpackage

// File: rtl/phy_regbank.sv
module phy_regbank
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              link_up,
  input  logic              an_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ctrl_q
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (reg_can_wr(ADDR_W'(i))) begin : g_rw
      logic [DATA_W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)
          q_r <= reg_reset(ADDR_W'(i));
        else if (wr_en && (wr_addr == ADDR_W'(i)))
          q_r <= wr_data;
      end
      assign regs[i] = q_r;
    end else begin : g_ro
      assign regs[i] = reg_reset(ADDR_W'(i));
    end
  end

  // status register: live link and negotiation bits overlaid on constants
  always_comb begin
    rd_data = regs[rd_addr];
    if (rd_addr == REG_STAT) begin
      rd_data[STAT_LINK]    = link_up;
      rd_data[STAT_AN_DONE] = an_done;
    end
  end

  assign ctrl_q = regs[REG_CTRL];

endmodule

// File: rtl/phy_autoneg.sv
module phy_autoneg #(
  parameter int unsigned DELAY_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic wire_link_ok,
  input  logic start,
  output logic link_up,
  output logic an_done,
  output logic pending,
  output logic done_evt
);

  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_evt = pending && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt_q   <= '0;
      link_up <= wire_link_ok;
      an_done <= 1'b0;
    end else if (start) begin
      pending <= 1'b1;
      cnt_q   <= RELOAD;
      link_up <= 1'b0;
      an_done <= 1'b0;
    end else if (done_evt) begin
      pending <= 1'b0;
      link_up <= 1'b1;
      an_done <= 1'b1;
    end else if (pending) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/phy_mgmt_emu.sv
module phy_mgmt_emu
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 50_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wire_link_ok,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  output logic [CMD_W-1:0]   cmd_rdata,
  input  logic               mask_wr,
  input  logic [CAUSE_W-1:0] mask_wdata,
  input  logic               cause_ack_wr,
  input  logic [CAUSE_W-1:0] cause_ack_bits,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq,
  output logic               link_up,
  output logic               loopback
);

  logic [CMD_W-1:0]   cmd_q;
  logic               pend_q;
  logic [CAUSE_W-1:0] mask_q;
  logic [CAUSE_W-1:0] cause_q;

  // decoded command fields
  mdi_op_e           cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              cmd_ie;
  assign cmd_op   = mdi_op_e'(cmd_q[F_OP_LSB +: 2]);
  assign cmd_addr = cmd_q[F_REG_LSB +: ADDR_W];
  assign cmd_data = cmd_q[DATA_W-1:0];
  assign cmd_ie   = cmd_q[B_IE];

  // named events for the checker
  logic exec_fire, exec_wr, exec_rd, wr_ok, exec_err, an_start, mdi_cause_set;
  logic an_pending, an_done, an_done_evt;
  logic [DATA_W-1:0] rd_val, ctrl_q;

  assign exec_fire     = pend_q;
  assign exec_wr       = exec_fire && (cmd_op == OP_WR);
  assign exec_rd       = exec_fire && (cmd_op == OP_RD);
  assign wr_ok         = exec_wr && reg_can_wr(cmd_addr);
  assign exec_err      = (exec_wr && !reg_can_wr(cmd_addr)) ||
                         (exec_rd && !reg_can_rd(cmd_addr));
  assign an_start      = wr_ok && (cmd_addr == REG_CTRL) &&
                         cmd_data[CTRL_AN_EN] && cmd_data[CTRL_AN_RST];
  assign mdi_cause_set = exec_fire && cmd_ie;

  phy_regbank u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .wr_addr (cmd_addr),
    .wr_data (cmd_data),
    .rd_addr (cmd_addr),
    .link_up (link_up),
    .an_done (an_done),
    .rd_data (rd_val),
    .ctrl_q  (ctrl_q)
  );

  phy_autoneg #(.DELAY_CYC(DELAY_CYC)) u_an (
    .clk          (clk),
    .rst          (rst),
    .wire_link_ok (wire_link_ok),
    .start        (an_start),
    .link_up      (link_up),
    .an_done      (an_done),
    .pending      (an_pending),
    .done_evt     (an_done_evt)
  );

  // command register: capture, then complete one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
    end else if (cmd_wr) begin
      cmd_q          <= cmd_wdata;
      cmd_q[B_READY] <= 1'b0;
      cmd_q[B_ERR]   <= 1'b0;
      pend_q         <= 1'b1;
    end else if (exec_fire) begin
      pend_q         <= 1'b0;
      cmd_q[B_READY] <= 1'b1;
      cmd_q[B_ERR]   <= exec_err;
      if (exec_rd && reg_can_rd(cmd_addr))
        cmd_q[DATA_W-1:0] <= rd_val;
    end
  end

  // interrupt cause and mask
  logic [CAUSE_W-1:0] cause_set, cause_clr;
  always_comb begin
    cause_set         = '0;
    cause_set[CS_MDI] = mdi_cause_set;
    cause_set[CS_AN]  = an_done_evt;
    cause_clr         = cause_ack_wr ? cause_ack_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      if (mask_wr)
        mask_q <= mask_wdata;
      cause_q <= (cause_q & ~cause_clr) | cause_set;
    end
  end

  assign cmd_rdata = cmd_q;
  assign cause     = cause_q;
  assign irq       = |(mask_q & cause_q);
  assign loopback  = ctrl_q[CTRL_LOOP];

endmodule

// File: rtl/phy_mgmt_emu_chk.sv
module phy_mgmt_emu_chk
  import phy_mgmt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cmd_wr,
  input logic [CMD_W-1:0]   cmd_rdata,
  input logic               exec_fire,
  input logic               exec_err,
  input logic               mdi_cause_set,
  input logic [CAUSE_W-1:0] mask_q,
  input logic [CAUSE_W-1:0] cause,
  input logic               irq,
  input logic               an_start,
  input logic               an_pending,
  input logic               link_up,
  input logic               an_done
);

  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !cmd_rdata[B_READY]);

  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && !cmd_wr) |=> cmd_rdata[B_READY]);

  assert_err_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && exec_err && !cmd_wr) |=> cmd_rdata[B_ERR]);

  assert_ie_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cause[CS_MDI]) |-> $past(mdi_cause_set));

  assert_irq_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (mdi_cause_set && mask_q[CS_MDI]) |=> irq);

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cause == '0) |-> !irq);

  assert_an_start_R7: assert property (@(posedge clk) disable iff (rst)
    an_start |=> (!link_up && !an_done));

  assert_link_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(an_pending));

endmodule

bind phy_mgmt_emu phy_mgmt_emu_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .cmd_wr        (cmd_wr),
  .cmd_rdata     (cmd_rdata),
  .exec_fire     (exec_fire),
  .exec_err      (exec_err),
  .mdi_cause_set (mdi_cause_set),
  .mask_q        (mask_q),
  .cause         (cause),
  .irq           (irq),
  .an_start      (an_start),
  .an_pending    (an_pending),
  .link_up       (link_up),
  .an_done       (an_done)
);

// File: tb/phy_mgmt_emu_tb.sv
module phy_mgmt_emu_tb_top;

  localparam int unsigned D = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wire_link_ok = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mask_wr = 1'b0;
  logic [1:0]  mask_wdata = '0;
  logic        cause_ack_wr = 1'b0;
  logic [1:0]  cause_ack_bits = '0;
  logic [1:0]  cause;
  logic        irq, link_up, loopback;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  phy_mgmt_emu #(.DELAY_CYC(D)) dut_i (
    .clk            (clk),
    .rst            (rst),
    .wire_link_ok   (wire_link_ok),
    .cmd_wr         (cmd_wr),
    .cmd_wdata      (cmd_wdata),
    .cmd_rdata      (cmd_rdata),
    .mask_wr        (mask_wr),
    .mask_wdata     (mask_wdata),
    .cause_ack_wr   (cause_ack_wr),
    .cause_ack_bits (cause_ack_bits),
    .cause          (cause),
    .irq            (irq),
    .link_up        (link_up),
    .loopback       (loopback)
  );

  // word layout: data 15:0, reg 20:16, op 27:26 (01 wr, 10 rd), ready 28, ie 29, err 30
  localparam logic [31:0] RD = 32'h0800_0000;
  localparam logic [31:0] WR = 32'h0400_0000;

  // {command, expected command register after completion}
  localparam logic [63:0] VEC [8] = '{
    {RD | 32'h0000_0000, 32'h1800_1140},  // reg0 reset value
    {RD | 32'h0001_0000, 32'h1801_794D},  // status reset value
    {RD | 32'h0002_0000, 32'h1802_0141},  // id reset value
    {WR | 32'h0004_0A5A, 32'h1404_0A5A},  // writable reg4
    {RD | 32'h0004_0000, 32'h1804_0A5A},  // read back reg4
    {WR | 32'h0001_1234, 32'h5401_1234},  // read-only status: error
    {RD | 32'h0001_0000, 32'h1801_794D},  // status unchanged
    {RD | 32'h0007_0000, 32'h5807_0000}   // absent reg7: error
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the completion edge
  task automatic do_cmd(input logic [31:0] w);
    cmd_wr = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_mask(input logic [1:0] m);
    mask_wr = 1'b1;
    mask_wdata = m;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R11 reset state
    chk("R11 cmd reg after reset", cmd_rdata, 32'h0);
    chk("R11 link_up after reset", {31'b0, link_up}, 32'h1);
    chk("R11 loopback after reset", {31'b0, loopback}, 32'h0);
    chk("R6 irq/cause after reset", {29'b0, irq, cause}, 32'h0);

    // R1 one-cycle busy
    cmd_wr = 1'b1;
    cmd_wdata = RD | 32'h1000_0000;  // ready bit set by host must be cleared
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R1 ready low while busy", {31'b0, cmd_rdata[28]}, 32'h0);
    @(negedge clk);
    chk("R1 ready after one cycle", cmd_rdata, 32'h1800_1140);

    // table: R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      do_cmd(VEC[i][63:32]);
      chk($sformatf("R2/R3/R4 vector %0d", i), cmd_rdata, VEC[i][31:0]);
    end
    chk("R5 no cause without ie", {30'b0, cause}, 32'h0);

    // R5 R6 cause gating and irq
    set_mask(2'b01);
    do_cmd(RD | 32'h2000_0000);
    chk("R5 ie read data", cmd_rdata, 32'h3800_1140);
    chk("R5 cause bit0 set with ie", {30'b0, cause}, 32'h1);
    chk("R6 irq with mask", {31'b0, irq}, 32'h1);
    set_mask(2'b00);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    set_mask(2'b01);
    cause_ack_wr = 1'b1;
    cause_ack_bits = 2'b01;
    @(negedge clk);
    cause_ack_wr = 1'b0;
    chk("R6 ack clears cause", {29'b0, irq, cause}, 32'h0);

    // R10 loopback and non-starting control writes
    do_cmd(WR | 32'h0000_5140);
    chk("R10 loopback set", {30'b0, loopback, link_up}, 32'h3);
    do_cmd(WR | 32'h0000_0340);
    chk("R10 restart without enable keeps link", {30'b0, loopback, link_up}, 32'h1);

    // R7 R8 auto-negotiation
    do_cmd(WR | 32'h0000_1340);
    chk("R7 link drops", {31'b0, link_up}, 32'h0);
    do_cmd(RD | 32'h0001_0000);
    chk("R7 status during negotiation", {16'b0, cmd_rdata[15:0]}, 32'h7949);
    repeat (D - 3) @(negedge clk);
    chk("R8 still down at last delay cycle", {31'b0, link_up}, 32'h0);
    @(negedge clk);
    chk("R8 link up after delay", {31'b0, link_up}, 32'h1);
    chk("R8 negotiation cause", {31'b0, cause[1]}, 32'h1);
    do_cmd(RD | 32'h0001_0000);
    chk("R8 status after negotiation", {16'b0, cmd_rdata[15:0]}, 32'h796D);

    // R9 restart reloads delay
    do_cmd(WR | 32'h0000_1340);
    repeat (5) @(negedge clk);
    do_cmd(WR | 32'h0000_1340);
    repeat (D - 1) @(negedge clk);
    chk("R9 still down after reload", {31'b0, link_up}, 32'h0);
    @(negedge clk);
    chk("R9 up after reloaded delay", {31'b0, link_up}, 32'h1);

    // R11 reset cancels pending delay
    do_cmd(WR | 32'h0000_1340);
    do_reset();
    repeat (D + 5) @(negedge clk);
    chk("R11 cancel: link and cause", {29'b0, link_up, cause}, 32'h4);
    do_cmd(RD | 32'h0001_0000);
    chk("R11 cancel: status", {16'b0, cmd_rdata[15:0]}, 32'h794D);

    // R11 reset with external link down
    wire_link_ok = 1'b0;
    do_reset();
    chk("R11 link forced low", {31'b0, link_up}, 32'h0);
    do_cmd(RD | 32'h0001_0000);
    chk("R11 status with link down", {16'b0, cmd_rdata[15:0]}, 32'h7949);
    wire_link_ok = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule